// File: doc/BRIEF.md
# UART Receive FIFO Status Controller

This block holds the receive side of a UART past the deserializer. Each byte that arrives is written into a sixteen-entry FIFO together with its parity and framing error bits. A programmable trigger level decides when the data-full flag rises. That flag also drives the receive request output, which is used both as the interrupt and as the DMA request.

Software reaches the block through a small register port with four locations: a data location that pops the FIFO, a status location, a fill count and a control location. Both status flags clear only by a two-step handshake: the flag must first be read while it is 1, and then written with 0. A DMA engine drains the FIFO through a separate read strobe, and each DMA read drops the data-full flag without any handshake.

When a byte arrives while the FIFO is full, the overrun flag sets. From then on, every arriving byte is discarded until software clears the overrun flag.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: With reception enabled and no overrun pending, each arriving byte is stored. Bytes leave in arrival order. The count location (address 2) reads the number of stored bytes in bits [4:0], and that number never exceeds 16.
- R2: The data-full flag (status bit 0) sets once the stored count is at or above the trigger level. The level is chosen by control bits [2:1]: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. The flag stays set while the count falls until it is cleared.
- R3: A status write with bit 0 equal to 0 clears the data-full flag only if a status read returned that flag as 1 earlier. A write of 0 without such a read has no effect.
- R4: If the count is still at or above the trigger level after a clear, the data-full flag sets again on the following cycle.
- R5: A DMA read strobe pops the head byte onto the DMA data output and clears the data-full flag.
- R6: A byte that arrives while 16 bytes are stored is dropped, and the overrun flag (status bit 1) sets. While that flag is 1, every arriving byte is dropped. The flag clears only by a status read that returned it as 1, followed by a status write with bit 1 equal to 0.
- R7: While the receive-enable bit (control bit 0) is 0, arriving bytes are dropped and the overrun flag does not set.
- R8: Status bit 2 shows the parity error bit of the head entry, and status bit 3 shows its framing error bit. Both read 0 when the FIFO is empty.
- R9: A read of the data location (address 0) pops the head byte. When the FIFO is empty, the read returns the last byte popped and leaves the count at 0.
- R10: The receive request output equals the data-full flag, so it rises whenever that flag changes from 0 to 1.
- R11: After reset, the FIFO is empty, both flags are 0, reception is disabled, the trigger select is 00 and the last-byte value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A deserialized byte is present this cycle |
| rx_data | input | 8 | Deserialized byte |
| rx_perr | input | 1 | Parity error for this byte |
| rx_ferr | input | 1 | Framing error for this byte |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 2 | 0 data, 1 status, 2 count, 3 control |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed location (combinational) |
| dma_rd | input | 1 | DMA pop strobe |
| dma_rdata | output | 8 | Head byte, or the last popped byte when the FIFO is empty |
| rx_req | output | 1 | Receive interrupt and DMA request |

## Verification
The checker watches several properties on every cycle:
- the fill count never passes the FIFO depth;
- the data-full flag rises one cycle after the count reaches the trigger;
- the data-full flag holds without a clearing event and falls after a DMA read;
- the overrun flag stays up until a status write;
- the count never grows while overrun is pending or reception is disabled.

Some behaviours show only in the bench's scenarios, which compare the design against a reference model:
- the read-1-then-write-0 handshake;
- arrival order and the per-entry error bits;
- the last-byte value returned on an empty read;
- the re-set of the flag after a clear.

// File: rtl/uart_rx_fifo_ctl.sv
module uart_rx_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          cpu_sel,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dma_rd,
  output logic [DW-1:0] dma_rdata,
  output logic          rx_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CNT = 2'd2, A_CTRL = 2'd3;

  logic [DW+1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q, trig_lvl;
  logic [DW-1:0] last_q;
  logic [1:0]    tsel_q;
  logic          en_q, rdf_q, rdf_arm, ovr_q, ovr_arm;

  logic [DW+1:0] head;
  logic empty, full, rx_take, push, pop, ovr_set, trig_hit;
  logic acc_rd, acc_wr, st_rd, st_wr, rdf_clr, ovr_clr;

  assign acc_rd   = cpu_sel & ~cpu_we;
  assign acc_wr   = cpu_sel & cpu_we;
  assign st_rd    = acc_rd & (cpu_addr == A_STAT);
  assign st_wr    = acc_wr & (cpu_addr == A_STAT);
  assign empty    = (count_q == '0);
  assign full     = (count_q == CW'(DEPTH));
  assign head     = mem[rd_ptr];
  assign rx_take  = rx_valid & en_q & ~ovr_q;
  assign push     = rx_take & ~full;
  assign ovr_set  = rx_take & full;
  assign pop      = ~empty & (dma_rd | (acc_rd & (cpu_addr == A_DATA)));
  assign trig_hit = (count_q >= trig_lvl);
  assign rdf_clr  = dma_rd | (st_wr & ~cpu_wdata[0] & rdf_arm);
  assign ovr_clr  = st_wr & ~cpu_wdata[1] & ovr_arm;

  always_comb begin
    case (tsel_q)
      2'd0:    trig_lvl = CW'(TRIG0);
      2'd1:    trig_lvl = CW'(TRIG1);
      2'd2:    trig_lvl = CW'(TRIG2);
      default: trig_lvl = CW'(TRIG3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {rx_ferr, rx_perr, rx_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      last_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        last_q <= head[DW-1:0];
      end
      if (push && !pop)      count_q <= count_q + 1'b1;
      else if (pop && !push) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdf_q   <= 1'b0;
      rdf_arm <= 1'b0;
      ovr_q   <= 1'b0;
      ovr_arm <= 1'b0;
      en_q    <= 1'b0;
      tsel_q  <= 2'd0;
    end else begin
      rdf_q   <= rdf_clr ? 1'b0 : (rdf_q | trig_hit);
      rdf_arm <= rdf_q & ~rdf_clr & (rdf_arm | st_rd);
      ovr_q   <= ovr_clr ? 1'b0 : (ovr_q | ovr_set);
      ovr_arm <= ovr_q & ~ovr_clr & (ovr_arm | st_rd);
      if (acc_wr && cpu_addr == A_CTRL) begin
        en_q   <= cpu_wdata[0];
        tsel_q <= cpu_wdata[2:1];
      end
    end
  end

  logic [DW-1:0] head_byte;
  assign head_byte = empty ? last_q : head[DW-1:0];
  assign dma_rdata = head_byte;
  assign rx_req    = rdf_q;

  always_comb begin
    case (cpu_addr)
      A_DATA:  cpu_rdata = head_byte;
      A_STAT:  cpu_rdata = {{(DW-4){1'b0}}, ~empty & head[DW+1], ~empty & head[DW], ovr_q, rdf_q};
      A_CNT:   cpu_rdata = {{(DW-CW){1'b0}}, count_q};
      default: cpu_rdata = {{(DW-3){1'b0}}, tsel_q, en_q};
    endcase
  end
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          rdf,
  input logic          ovr,
  input logic          ge,
  input logic          dma_rd,
  input logic          st_wr,
  input logic          en
);
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_flag_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdf && ge && !dma_rd) |=> rdf);
  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rdf && !st_wr && !dma_rd) |=> rdf);
  a_r5_dma_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rdf && dma_rd) |=> !rdf);
  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !st_wr) |=> ovr);
  a_r6_ovr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> (count <= $past(count)));
  a_r7_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count <= $past(count)));
endmodule

bind uart_rx_fifo_ctl uart_rx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count_q), .rdf(rdf_q), .ovr(ovr_q),
  .ge(trig_hit), .dma_rd(dma_rd), .st_wr(st_wr), .en(en_q)
);

// File: tb/tb_uart_rx_fifo_ctl.sv
module tb_uart_rx_fifo_ctl;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, cpu_sel = 0, cpu_we = 0, dma_rd = 0;
  logic [7:0] rx_data = 0, cpu_wdata = 0, cpu_rdata, dma_rdata;
  logic [1:0] cpu_addr = 0;
  logic rx_req;

  uart_rx_fifo_ctl dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [9:0] q[$];
  bit m_rdf, m_rarm, m_ovr, m_oarm, m_en;
  logic [1:0] m_tsel;
  logic [7:0] m_last;

  function automatic int trig_of(logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic logic [7:0] exp_status();
    logic p = 0, f = 0;
    if (q.size() != 0) begin p = q[0][8]; f = q[0][9]; end
    return {4'b0, f, p, m_ovr, m_rdf};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    if (q.size() >= trig_of(m_tsel)) m_rdf = 1;
    check("R10 req", rx_req, m_rdf);
  endtask

  task automatic op_push(logic [7:0] d, logic p, logic f);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f;
    @(negedge clk); rx_valid = 0;
    @(negedge clk);
    if (m_en && !m_ovr) begin
      if (q.size() == 16) m_ovr = 1; else q.push_back({f, p, d});
    end
    settle();
  endtask

  task automatic cpu_op(bit we, logic [1:0] a, logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk); cpu_sel = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1 rd = cpu_rdata;
    @(negedge clk); cpu_sel = 0; cpu_we = 0;
    @(negedge clk);
  endtask

  task automatic op_read(string req, logic [1:0] a);
    logic [7:0] rd, e;
    case (a)
      2'd0: e = q.size() ? q[0][7:0] : m_last;
      2'd1: e = exp_status();
      2'd2: e = 8'(q.size());
      default: e = {5'b0, m_tsel, m_en};
    endcase
    cpu_op(0, a, 8'h00, rd);
    check(req, rd, e);
    if (a == 2'd0 && q.size() != 0) begin m_last = q[0][7:0]; void'(q.pop_front()); end
    if (a == 2'd1) begin if (m_rdf) m_rarm = 1; if (m_ovr) m_oarm = 1; end
    settle();
  endtask

  task automatic op_write(logic [1:0] a, logic [7:0] wd);
    logic [7:0] rd;
    cpu_op(1, a, wd, rd);
    if (a == 2'd1) begin
      if (!wd[0] && m_rarm) begin m_rdf = 0; m_rarm = 0; end
      if (!wd[1] && m_oarm) begin m_ovr = 0; m_oarm = 0; end
    end else if (a == 2'd3) begin
      m_en = wd[0]; m_tsel = wd[2:1];
    end
    settle();
  endtask

  task automatic op_dma(string req);
    logic [7:0] rd, e;
    e = q.size() ? q[0][7:0] : m_last;
    @(negedge clk); dma_rd = 1;
    #1 rd = dma_rdata;
    @(negedge clk); dma_rd = 0;
    @(negedge clk);
    check(req, rd, e);
    if (q.size() != 0) begin m_last = q[0][7:0]; void'(q.pop_front()); end
    m_rdf = 0; m_rarm = 0;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 req", rx_req, 0);
    op_read("R11 status", 2'd1);
    op_read("R11 count", 2'd2);
    op_read("R11 ctrl", 2'd3);
    op_read("R11 data", 2'd0);
    // R7 disabled drops
    op_push(8'h11, 0, 0);
    op_read("R7 count", 2'd2);
    // R2 trigger 4
    op_write(2'd3, 8'h03);
    for (int i = 0; i < 3; i++) op_push(8'hA0 + 8'(i), 0, 0);
    check("R2 below trig", rx_req, 0);
    op_push(8'hA3, 1, 0);
    check("R2 at trig", rx_req, 1);
    // R3 write 0 without prior read ignored
    op_write(2'd1, 8'h00);
    check("R3 unarmed", rx_req, 1);
    op_read("R9 pop", 2'd0);
    op_read("R3 read1", 2'd1);
    op_write(2'd1, 8'h02);
    check("R3 cleared", rx_req, 0);
    op_push(8'hA4, 0, 1);
    // R4 re-set after clear
    op_read("R8 head", 2'd1);
    op_write(2'd1, 8'h02);
    check("R4 reset again", rx_req, 1);
    // R5 DMA clears
    op_dma("R5 dma data");
    check("R5 cleared", rx_req, 0);
    // R6 overrun
    for (int i = 0; i < 14; i++) op_push(8'h30 + 8'(i), 1, 1);
    op_read("R1 full count", 2'd2);
    op_push(8'hEE, 0, 0);
    op_read("R6 status", 2'd1);
    op_read("R6 count", 2'd2);
    op_read("R1 order", 2'd0);
    op_push(8'hEF, 0, 0);
    op_read("R6 dropped", 2'd2);
    op_write(2'd1, 8'h01);
    op_read("R6 cleared", 2'd1);
    op_push(8'hF0, 0, 0);
    op_read("R6 accepted", 2'd2);
    for (int i = 0; i < 17; i++) op_read("R1 drain", 2'd0);
    op_read("R9 empty", 2'd0);
    op_read("R9 count", 2'd2);
    op_read("R8 empty", 2'd1);
    // random mix
    for (int n = 0; n < 700; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 42) op_push(8'($urandom), $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
      else if (r < 56) op_read("R1 data", 2'd0);
      else if (r < 64) op_dma("R5 data");
      else if (r < 74) op_read("R8 status", 2'd1);
      else if (r < 84) op_write(2'd1, {6'b0, 2'($urandom)});
      else if (r < 91) op_read("R1 count", 2'd2);
      else if (r < 95) op_write(2'd3, {5'b0, 2'($urandom), $urandom_range(0, 7) != 0});
      else op_read("R2 ctrl", 2'd3);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule